// File: doc/BRIEF.md
# Binary Shortest-LFSR Synthesizer with Unspecified Symbols

This engine receives a stream of three-valued symbols (0, 1 or unspecified) one per handshake and, after every symbol, holds the connection polynomial and length of the shortest binary linear feedback shift register that reproduces every resolved symbol seen so far. It runs the binary Berlekamp–Massey recursion one symbol at a time, keeping a correction polynomial, the shift distance since the last length change, and a shift register of the resolved history.

An unspecified symbol takes the bit the current register predicts. Its discrepancy is therefore zero and neither the polynomial nor the length grows. The chosen bit comes out next to every result, so a pattern generator seeded with the first L resolved bits and the final polynomial will reproduce the full resolved stream. A `start` pulse clears the engine. The symbol flagged as last moves it to a finished state, where it ignores input until the next `start`.

Top module: `bm_synth_top`

## Requirements
- R1: After reset, `sym_ready` and `done` are 0, `poly` is 1 (only bit 0 set; bit i is the coefficient of x^i) and `lin_len` is 0. One cycle after a `start` pulse the same values hold and `sym_ready` is 1.
- R2: A symbol is taken on a clock edge where `sym_valid` and `sym_ready` are both 1. `sym_ready` is 0 in the following cycle, and one cycle after that `res_valid` is 1 for one cycle with the updated `poly`, `lin_len` and `res_bit`.
- R3: A specified symbol equal to the prediction (XOR of history bits s[j-i] at the taps i where poly bit i is 1) leaves `poly` and `lin_len` unchanged, and `res_bit` equals the symbol.
- R4: A specified symbol that differs from the prediction changes `poly` so that it produces all symbols so far. When twice the old length is at most the count of earlier symbols, the length becomes that count plus one minus the old length. Otherwise the length stays the same.
- R5: `lin_len` never exceeds the number of symbols taken since `start`.
- R6: A symbol with `sym_x` = 1 (unspecified; `sym_bit` ignored) gets the predicted bit on `res_bit`, and `poly` and `lin_len` stay unchanged.
- R7: The stream 1010011011 ends with `poly` = 1 + x^2 + x^4 + x^5 and `lin_len` = 5, and the 4th, 7th and 10th symbols leave the result unchanged.
- R8: The stream 100100100100 ends with `poly` = 1 + x^3 and `lin_len` = 3.
- R9: The stream 011X0XX11XXXXXX0X11X1X1X00X1XXX ends with `poly` = 1 + x^3 + x^5, and its resolved bits read 0110011111000110111010100001001.
- R10: After the result for a symbol with `sym_last` = 1, `done` is 1 and `sym_ready` is 0. Further `sym_valid` has no effect on any output until `start`.
- R11: Bit 0 of `poly` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears the engine and opens a new stream |
| sym_valid | input | 1 | Symbol offered |
| sym_ready | output | 1 | Engine can take a symbol |
| sym_x | input | 1 | 1 = symbol is unspecified |
| sym_bit | input | 1 | Symbol value when specified |
| sym_last | input | 1 | Marks the final symbol of the stream |
| res_valid | output | 1 | One-cycle pulse: result for the last symbol |
| res_bit | output | 1 | Resolved value of that symbol |
| poly | output | MAX_DEG+1 | Connection polynomial, bit i = coefficient of x^i |
| lin_len | output | clog2(MAX_SYMS+1) | Current linear complexity |
| done | output | 1 | Stream finished |

## Verification
Three fixed streams with known answers separate the cases. The alternating-then-irregular binary stream needs several length jumps and some zero-discrepancy steps. The period-three stream should settle at a short length. The mostly-unspecified stream shows whether don't-cares are resolved by prediction and not by a fixed value, because any other choice gives a longer register or different resolved bits. Random streams of mixed 0, 1 and X symbols are checked at every step against a bench model of the recursion, and each step is tagged as a match, a mismatch or an unspecified symbol. Separate checks cover input arriving after completion and a restart.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TAKE = 2'd1,
    ST_CALC = 2'd2,
    ST_FIN  = 2'd3
  } bm_state_t;
endpackage

// File: rtl/bm_predict.sv
// Predicts the next bit from the taps and history, resolves unspecified symbols.
module bm_predict #(
  parameter int MAX_DEG = 16
) (
  input  logic [MAX_DEG:1]   taps,
  input  logic [MAX_DEG-1:0] hist,   // hist[i-1] holds s[j-i]
  input  logic               in_x,
  input  logic               in_bit,
  output logic               resolved,
  output logic               disc
);
  logic pred;
  assign pred     = ^(taps & hist);
  assign resolved = in_x ? pred : in_bit;
  assign disc     = resolved ^ pred;
endmodule

// File: rtl/bm_update.sv
// One step of the binary recursion on polynomial, correction term, length and shift.
module bm_update #(
  parameter int MAX_DEG = 16,
  parameter int CW      = 7
) (
  input  logic [MAX_DEG:0] c_in,
  input  logic [MAX_DEG:0] b_in,
  input  logic [CW-1:0]    len_in,
  input  logic [CW-1:0]    shf_in,
  input  logic [CW-1:0]    cnt_in,
  input  logic             disc,
  output logic [MAX_DEG:0] c_out,
  output logic [MAX_DEG:0] b_out,
  output logic [CW-1:0]    len_out,
  output logic [CW-1:0]    shf_out
);
  logic [CW:0] twice_len;
  assign twice_len = {len_in, 1'b0};

  always_comb begin
    c_out   = c_in;
    b_out   = b_in;
    len_out = len_in;
    shf_out = shf_in + CW'(1);
    if (disc) begin
      c_out = c_in ^ (b_in << shf_in);
      if (twice_len <= {1'b0, cnt_in}) begin
        len_out = cnt_in + CW'(1) - len_in;
        b_out   = c_in;
        shf_out = CW'(1);
      end
    end
  end
endmodule

// File: rtl/bm_synth_top.sv
module bm_synth_top
  import bm_pkg::*;
#(
  parameter int MAX_DEG  = 16,
  parameter int MAX_SYMS = 64,
  localparam int CW = $clog2(MAX_SYMS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic             sym_x,
  input  logic             sym_bit,
  input  logic             sym_last,
  output logic             res_valid,
  output logic             res_bit,
  output logic [MAX_DEG:0] poly,
  output logic [CW-1:0]    lin_len,
  output logic             done
);
  localparam logic [MAX_DEG:0] ONE_POLY = {{MAX_DEG{1'b0}}, 1'b1};

  bm_state_t          state_q;
  logic [MAX_DEG:0]   c_q, b_q, c_n, b_n;
  logic [CW-1:0]      len_q, shf_q, cnt_q, len_n, shf_n;
  logic [MAX_DEG-1:0] hist_q;
  logic               x_q, bit_q, last_q;
  logic               resolved, disc;
  logic               take;

  assign take      = sym_valid && (state_q == ST_TAKE);
  assign sym_ready = (state_q == ST_TAKE);
  assign done      = (state_q == ST_FIN);
  assign poly      = c_q;
  assign lin_len   = len_q;

  bm_predict #(.MAX_DEG(MAX_DEG)) u_pred (
    .taps     (c_q[MAX_DEG:1]),
    .hist     (hist_q),
    .in_x     (x_q),
    .in_bit   (bit_q),
    .resolved (resolved),
    .disc     (disc)
  );

  bm_update #(.MAX_DEG(MAX_DEG), .CW(CW)) u_upd (
    .c_in    (c_q),
    .b_in    (b_q),
    .len_in  (len_q),
    .shf_in  (shf_q),
    .cnt_in  (cnt_q),
    .disc    (disc),
    .c_out   (c_n),
    .b_out   (b_n),
    .len_out (len_n),
    .shf_out (shf_n)
  );

  always_ff @(posedge clk) begin
    res_valid <= 1'b0;
    if (rst || start) begin
      state_q <= rst ? ST_IDLE : ST_TAKE;
      c_q     <= ONE_POLY;
      b_q     <= ONE_POLY;
      len_q   <= '0;
      shf_q   <= CW'(1);
      cnt_q   <= '0;
      hist_q  <= '0;
      x_q     <= 1'b0;
      bit_q   <= 1'b0;
      last_q  <= 1'b0;
      res_bit <= 1'b0;
    end else begin
      case (state_q)
        ST_TAKE: if (take) begin
          x_q     <= sym_x;
          bit_q   <= sym_bit;
          last_q  <= sym_last;
          state_q <= ST_CALC;
        end
        ST_CALC: begin
          c_q       <= c_n;
          b_q       <= b_n;
          len_q     <= len_n;
          shf_q     <= shf_n;
          cnt_q     <= cnt_q + CW'(1);
          hist_q    <= {hist_q[MAX_DEG-2:0], resolved};
          res_bit   <= resolved;
          res_valid <= 1'b1;
          state_q   <= last_q ? ST_FIN : ST_TAKE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bm_synth_chk.sv
module bm_synth_chk
  import bm_pkg::*;
#(
  parameter int MAX_DEG = 16,
  parameter int CW      = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             sym_valid,
  input logic             sym_ready,
  input logic             sym_last,
  input logic             res_valid,
  input logic [MAX_DEG:0] poly,
  input logic [CW-1:0]    lin_len,
  input logic [CW-1:0]    cnt_q,
  input logic             x_q,
  input bm_state_t        state_q,
  input logic             done
);
  AST_CONST_TERM: assert property (@(posedge clk) disable iff (rst) poly[0]); // R11

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (lin_len <= cnt_q)); // R5

  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst || start)
    (sym_valid && sym_ready) |=> !sym_ready); // R2

  AST_RESULT_TIME: assert property (@(posedge clk) disable iff (rst || start)
    (sym_valid && sym_ready) |=> !res_valid ##1 res_valid); // R2

  AST_X_HOLDS: assert property (@(posedge clk) disable iff (rst || start)
    (state_q == ST_CALC && x_q) |=> ($stable(poly) && $stable(lin_len))); // R6

  AST_DONE_LAST: assert property (@(posedge clk) disable iff (rst || start)
    (sym_valid && sym_ready && sym_last) |=> ##1 (done && !sym_ready)); // R10

  AST_FIN_FROZEN: assert property (@(posedge clk) disable iff (rst || start)
    done |=> ($stable(poly) && $stable(lin_len) && !res_valid && done)); // R10
endmodule

bind bm_synth_top bm_synth_chk #(.MAX_DEG(MAX_DEG), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .sym_valid (sym_valid),
  .sym_ready (sym_ready),
  .sym_last  (sym_last),
  .res_valid (res_valid),
  .poly      (poly),
  .lin_len   (lin_len),
  .cnt_q     (cnt_q),
  .x_q       (x_q),
  .state_q   (state_q),
  .done      (done)
);

// File: tb/sim_bm_synth_top.sv
`timescale 1ns/1ps
module sim_bm_synth_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int MS = 64;
  localparam int CW = $clog2(MS + 1);

  logic clk = 1'b0;
  logic rst, start, sym_valid, sym_x, sym_bit, sym_last;
  logic sym_ready, res_valid, res_bit, done;
  logic [N:0] poly;
  logic [CW-1:0] lin_len;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bm_synth_top #(.MAX_DEG(N), .MAX_SYMS(MS)) u0 (
    .clk(clk), .rst(rst), .start(start), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_x(sym_x), .sym_bit(sym_bit), .sym_last(sym_last), .res_valid(res_valid),
    .res_bit(res_bit), .poly(poly), .lin_len(lin_len), .done(done));

  // reference model state
  logic [N:0]   mC, mB;
  logic [N-1:0] mh;
  int mL, mm, mcnt;
  string rtag;

  function automatic void model_clear();
    mC = 1; mB = 1; mh = '0; mL = 0; mm = 1; mcnt = 0;
  endfunction

  function automatic logic model_step(input logic x, input logic b);
    logic p, s, d;
    logic [N:0] t;
    p = 1'b0;
    for (int i = 1; i <= N; i++) if (mC[i] && i <= mcnt) p ^= mh[i-1];
    s = x ? p : b;
    d = s ^ p;
    rtag = x ? "R6" : (d ? "R4" : "R3");
    if (d) begin
      t = mC;
      for (int i = 0; i <= N; i++) if (mB[i] && i + mm <= N) mC[i+mm] ^= 1'b1;
      if (2*mL <= mcnt) begin mL = mcnt + 1 - mL; mB = t; mm = 1; end
      else mm++;
    end else mm++;
    mh = {mh[N-2:0], s};
    mcnt++;
    return s;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    model_clear();
    check("R1", "ready after start", sym_ready, 1);
    check("R1", "poly after start", poly, 1);
    check("R1", "len after start", lin_len, 0);
  endtask

  // sends one symbol, checks timing and the result against the model
  task automatic send(input logic x, input logic b, input logic last, output logic rb);
    logic exp_b;
    @(negedge clk);
    sym_valid = 1'b1; sym_x = x; sym_bit = b; sym_last = last;
    @(negedge clk);
    sym_valid = 1'b0; sym_last = 1'b0;
    check("R2", "ready low while computing", sym_ready, 0);
    check("R2", "no early result", res_valid, 0);
    exp_b = model_step(x, b);
    @(negedge clk);
    check("R2", "result pulse", res_valid, 1);
    check(rtag, "resolved bit", res_bit, exp_b);
    check(rtag, "poly", poly, mC);
    check(rtag, "length", lin_len, mL);
    check("R5", "length bound", (lin_len <= mcnt), 1);
    check("R11", "constant term", poly[0], 1);
    if (last) begin
      check("R10", "done", done, 1);
      check("R10", "ready after done", sym_ready, 0);
    end
    rb = res_bit;
  endtask

  task automatic run_str(input string s, output string res);
    logic rb;
    res = "";
    for (int i = 0; i < s.len(); i++) begin
      send(s[i] == "X", s[i] == "1", i == s.len() - 1, rb);
      res = {res, rb ? "1" : "0"};
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    string r;
    logic [N:0] p_hold;
    logic rb;
    rst = 1'b1; start = 1'b0; sym_valid = 1'b0; sym_x = 1'b0; sym_bit = 1'b0; sym_last = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "ready in reset state", sym_ready, 0);
    check("R1", "done in reset state", done, 0);
    check("R1", "poly in reset state", poly, 1);
    check("R1", "len in reset state", lin_len, 0);

    // R7
    do_start();
    run_str("1010011011", r);
    check("R7", "final poly", poly, 17'h35);
    check("R7", "final length", lin_len, 5);

    // R10: input after completion is ignored
    p_hold = poly;
    @(negedge clk); sym_valid = 1'b1; sym_bit = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R10", "no result when done", res_valid, 0);
    end
    sym_valid = 1'b0;
    check("R10", "poly frozen", poly, p_hold);
    check("R10", "length frozen", lin_len, 5);
    check("R10", "still done", done, 1);

    // R8
    do_start();
    run_str("100100100100", r);
    check("R8", "final poly", poly, 17'h9);
    check("R8", "final length", lin_len, 3);

    // R9
    do_start();
    run_str("011X0XX11XXXXXX0X11X1X1X00X1XXX", r);
    check("R9", "final poly", poly, 17'h29);
    check("R9", "final length", lin_len, 5);
    n_chk++;
    if (r != "0110011111000110111010100001001") begin
      n_bad++;
      $display("FAIL R9 resolved: actual %s expected 0110011111000110111010100001001", r);
    end

    // R1: restart in the middle of a stream
    do_start();
    send(1'b0, 1'b1, 1'b0, rb);
    send(1'b0, 1'b1, 1'b0, rb);
    do_start();

    // constrained random streams
    void'($urandom(32'h5eed_b3a5));
    for (int k = 0; k < 25; k++) begin
      int len;
      len = 1 + ($urandom % N);
      do_start();
      for (int i = 0; i < len; i++) begin
        logic x;
        x = (($urandom % 4) == 0);
        send(x, $urandom % 2, i == len - 1, rb);
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule